// File: doc/BRIEF.md
# Range TLB Invalidation Engine

This block holds two small sets of address translation entries for 32-bit I/O virtual addresses and runs the invalidation commands that software issues through a memory-mapped register port. Each entry maps one aligned page of 4 KB, 64 KB, 1 MB or 16 MB to a physical page. A refill port writes entries, and a combinational lookup port translates a virtual address against the set that the caller picks.

Software picks the target sets in a select register, then writes a command. A full command drops every entry of the selected sets at once. A range command starts a sweep that visits one entry per clock and drops each entry whose page overlaps an inclusive window `[start, end]`. Software then polls a busy bit or a completion register. The completion register is cleared by writing zero to it. While a sweep runs, entries it has not yet checked are hidden from lookups, so a stale translation is never returned.

Top module: `itlb_inval_top`

## Requirements
- R1: After reset every entry of both sets is invalid, so all lookups miss. The command, window start, window end, select and completion registers all read 0.
- R2: A lookup hits when a valid entry of the chosen set covers the address. The size code is 0=4 KB, 1=64 KB, 2=1 MB and 3=16 MB. The output address is the entry's physical page base ORed with the in-page offset. Several valid entries that match resolve to the lowest index. An address that no entry covers misses.
- R3: Writing 0x2 to the command register (offset 0x020) invalidates every entry of the selected sets at the clock edge that takes the write. The completion register reads nonzero from the following cycle on.
- R4: Writing 0x1 to the command register starts a sweep that checks one entry per cycle, starting at index 0. The sweep invalidates each entry of the selected sets whose span overlaps the inclusive window. Both window ends count as inside the window. The busy bit drops and completion becomes nonzero ENTRIES cycles after the write.
- R5: In the select register (offset 0x038), bit 0 enables set 0 and bit 1 enables set 1. A set whose bit is 0 is left untouched by either command.
- R6: The completion register (offset 0x12C) reads 1 when set. Writing 0 to it clears it. Writing a nonzero value leaves it unchanged.
- R7: Bit 31 of the command register reads 1 while a sweep is running. Any command written during that time is ignored.
- R8: During a sweep, a lookup into a swept set misses on every entry whose index is at or above the entry being checked.
- R9: Writing any value other than 0x1 or 0x2 to the command register has no effect.
- R10: The window start register (offset 0x024), the window end register (offset 0x028) and select bits [1:0] read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| fill_en | input | 1 | Refill write strobe |
| fill_set | input | 1 | Set that receives the refill |
| fill_idx | input | $clog2(ENTRIES) | Entry index written by the refill |
| fill_va | input | 32 | Virtual address of the page |
| fill_pa | input | 32 | Physical address of the page |
| fill_size | input | 2 | Page size code |
| lk_set | input | 1 | Set to search |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address |

## Verification
The assertions check on every cycle the following properties:
- The sweep index steps by one per busy cycle, and the sweep ends only on the last entry.
- No command is started while busy.
- A full command empties its set on the next cycle, and completion follows one cycle later.
- A zero write clears completion.
- A lookup hit is never taken from a valid-less set, or from an entry the sweep has not yet reached.

Only the bench scenarios can show the following:
- Which entries survive a window, including the cases where an entry touches the window by one byte or ends one byte before it.
- That a set left out of the select register keeps its entries.
- The exact sweep length seen at the busy bit.
- The translated addresses for each page size.

// File: rtl/itlb_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the range TLB invalidation engine.
// Assumes 32-bit addresses and exactly two entry sets.
package itlb_pkg;
    localparam int AW    = 32;
    localparam int NSETS = 2;
    localparam int RAW   = 12;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    localparam logic [RAW-1:0] OFS_CMD    = 12'h020;
    localparam logic [RAW-1:0] OFS_WSTART = 12'h024;
    localparam logic [RAW-1:0] OFS_WEND   = 12'h028;
    localparam logic [RAW-1:0] OFS_SEL    = 12'h038;
    localparam logic [RAW-1:0] OFS_DONE   = 12'h12C;

    localparam logic [AW-1:0] CMD_RANGE = 32'h1;
    localparam logic [AW-1:0] CMD_ALL   = 32'h2;

    // In-page offset mask for a page size code.
    function automatic logic [AW-1:0] span_mask(pg_size_e s);
        case (s)
            PG_4K:   span_mask = 32'h0000_0FFF;
            PG_64K:  span_mask = 32'h0000_FFFF;
            PG_1M:   span_mask = 32'h000F_FFFF;
            default: span_mask = 32'h00FF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/itlb_regs.sv
`timescale 1ns/1ps
// Register port: decodes writes, holds the window/select/completion state,
// and issues one-cycle command strobes. Assumes busy comes from the sweep.
module itlb_regs
    import itlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [RAW-1:0]   reg_addr,
    input  logic [AW-1:0]    reg_wdata,
    output logic [AW-1:0]    reg_rdata,
    input  logic             busy,
    input  logic             sweep_fin,
    output logic             full_go,
    output logic             range_go,
    output logic [AW-1:0]    win_lo,
    output logic [AW-1:0]    win_hi,
    output logic [NSETS-1:0] sel
);
    logic cmd_wr;
    logic done_q;
    logic full_pend;
    logic done_clr;

    // Command strobes: only taken while the engine is idle.
    always_comb begin
        cmd_wr   = reg_wr && (reg_addr == OFS_CMD) && !busy;
        full_go  = cmd_wr && (reg_wdata == CMD_ALL);
        range_go = cmd_wr && (reg_wdata == CMD_RANGE);
        done_clr = reg_wr && (reg_addr == OFS_DONE) && (reg_wdata == '0);
    end

    // Window and select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_lo <= '0;
            win_hi <= '0;
            sel    <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_WSTART) win_lo <= reg_wdata;
            if (reg_addr == OFS_WEND)   win_hi <= reg_wdata;
            if (reg_addr == OFS_SEL)    sel    <= reg_wdata[NSETS-1:0];
        end
    end

    // Completion flag: set by a finished command, cleared by a zero write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_pend <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            full_pend <= full_go;
            if (sweep_fin || full_pend) done_q <= 1'b1;
            else if (done_clr)          done_q <= 1'b0;
        end
    end

    // Read mux, combinational on the offset.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD:    reg_rdata = {busy, {(AW-1){1'b0}}};
            OFS_WSTART: reg_rdata = win_lo;
            OFS_WEND:   reg_rdata = win_hi;
            OFS_SEL:    reg_rdata = {{(AW-NSETS){1'b0}}, sel};
            OFS_DONE:   reg_rdata = {{(AW-1){1'b0}}, done_q};
            default:    reg_rdata = '0;
        endcase
    end

    // R3: full command reports completion one cycle after its write edge.
    assert_full_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full_go |=> ##1 done_q);

    // R6: a zero write with no finishing command clears completion.
    assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !sweep_fin && !full_pend) |=> !done_q);
endmodule

// File: rtl/itlb_sweep.sv
`timescale 1ns/1ps
// Range sweep sequencer: snapshots window and select on start, then steps
// an entry index once per cycle. Assumes ENTRIES >= 2.
module itlb_sweep
    import itlb_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    start_lo,
    input  logic [AW-1:0]    start_hi,
    input  logic [NSETS-1:0] start_sel,
    output logic             busy,
    output logic [IW-1:0]    idx,
    output logic [AW-1:0]    win_lo,
    output logic [AW-1:0]    win_hi,
    output logic [NSETS-1:0] win_sel,
    output logic             fin
);
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    // Final visit happens in the cycle the index sits on the last entry.
    assign fin = busy && (idx == LAST);

    // Sweep state: busy flag, index and window snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx     <= '0;
            win_lo  <= '0;
            win_hi  <= '0;
            win_sel <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            idx     <= '0;
            win_lo  <= start_lo;
            win_hi  <= start_hi;
            win_sel <= start_sel;
        end else if (busy) begin
            if (idx == LAST) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx  <= idx + 1'b1;
            end
        end
    end

    // R4: each busy cycle before the last advances the index by one.
    assert_sweep_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx != LAST && !start) |=> (busy && idx == $past(idx) + 1'b1));

    // R4: the sweep ends only after the last entry was visited.
    assert_sweep_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(idx) == LAST));

    // R7: no command reaches the sequencer while it is busy.
    assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/itlb_set.sv
`timescale 1ns/1ps
// One set of translation entries: refill, full flush, sweep-driven range
// kill and a combinational lowest-index-wins lookup. An invalidation in the
// same cycle as a refill of the same entry wins.
module itlb_set
    import itlb_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_en,
    input  logic [IW-1:0] fill_idx,
    input  logic [AW-1:0] fill_va,
    input  logic [AW-1:0] fill_pa,
    input  logic [1:0]    fill_size,
    input  logic          flush_all,
    input  logic          sw_busy,
    input  logic [IW-1:0] sw_idx,
    input  logic [AW-1:0] sw_lo,
    input  logic [AW-1:0] sw_hi,
    input  logic [AW-1:0] lk_va,
    output logic          lk_hit,
    output logic [AW-1:0] lk_pa
);
    logic [ENTRIES-1:0] vld_q;
    logic [AW-1:0]      va_q  [ENTRIES];
    logic [AW-1:0]      pa_q  [ENTRIES];
    pg_size_e           sz_q  [ENTRIES];
    logic [AW-1:0]      msk   [ENTRIES];
    logic [ENTRIES-1:0] kill;
    logic [ENTRIES-1:0] match;
    logic [IW-1:0]      hit_idx;
    logic [AW-1:0]      fmsk;

    assign fmsk = span_mask(pg_size_e'(fill_size));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic ovl;
        logic hidden;
        // Span of the entry, overlap with the window, and lookup match.
        assign msk[g]   = span_mask(sz_q[g]);
        assign ovl      = (va_q[g] <= sw_hi) && ((va_q[g] | msk[g]) >= sw_lo);
        assign kill[g]  = sw_busy && (sw_idx == IW'(g)) && ovl;
        assign hidden   = sw_busy && (IW'(g) >= sw_idx);
        assign match[g] = vld_q[g] && !hidden && ((lk_va & ~msk[g]) == va_q[g]);
    end

    // Valid bits: invalidation beats refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_all || kill[i])
                    vld_q[i] <= 1'b0;
                else if (fill_en && fill_idx == IW'(i))
                    vld_q[i] <= 1'b1;
            end
        end
    end

    // Entry payload, stored already aligned to the page size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                va_q[i] <= '0;
                pa_q[i] <= '0;
                sz_q[i] <= PG_4K;
            end
        end else if (fill_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_idx == IW'(i)) begin
                    va_q[i] <= fill_va & ~fmsk;
                    pa_q[i] <= fill_pa & ~fmsk;
                    sz_q[i] <= pg_size_e'(fill_size);
                end
            end
        end
    end

    // Lookup: lowest matching index wins.
    always_comb begin
        lk_hit  = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit  = 1'b1;
                hit_idx = IW'(i);
            end
        end
        lk_pa = lk_hit ? (pa_q[hit_idx] | (lk_va & msk[hit_idx])) : '0;
    end

    // R3: a full flush leaves the set empty.
    assert_flush_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (vld_q == '0));

    // R2: a hit always comes from a valid entry.
    assert_hit_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> vld_q[hit_idx]);

    // R8: during a sweep a hit only comes from an entry already checked.
    assert_no_stale_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_busy && lk_hit) |-> (hit_idx < sw_idx));
endmodule

// File: rtl/itlb_inval_top.sv
`timescale 1ns/1ps
// Top: register port, range sweep sequencer and two entry sets. Commands
// reach only the sets enabled in the select register.
module itlb_inval_top
    import itlb_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IW      = $clog2(ENTRIES),
    localparam int SW      = $clog2(NSETS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [AW-1:0]  reg_wdata,
    output logic [AW-1:0]  reg_rdata,
    input  logic           fill_en,
    input  logic [SW-1:0]  fill_set,
    input  logic [IW-1:0]  fill_idx,
    input  logic [AW-1:0]  fill_va,
    input  logic [AW-1:0]  fill_pa,
    input  logic [1:0]     fill_size,
    input  logic [SW-1:0]  lk_set,
    input  logic [AW-1:0]  lk_va,
    output logic           lk_hit,
    output logic [AW-1:0]  lk_pa
);
    logic             busy;
    logic             fin;
    logic             full_go;
    logic             range_go;
    logic [AW-1:0]    reg_lo;
    logic [AW-1:0]    reg_hi;
    logic [NSETS-1:0] reg_sel;
    logic [IW-1:0]    sw_idx;
    logic [AW-1:0]    sw_lo;
    logic [AW-1:0]    sw_hi;
    logic [NSETS-1:0] sw_sel;
    logic [NSETS-1:0] hit_v;
    logic [AW-1:0]    pa_v [NSETS];

    itlb_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .sweep_fin (fin),
        .full_go   (full_go),
        .range_go  (range_go),
        .win_lo    (reg_lo),
        .win_hi    (reg_hi),
        .sel       (reg_sel)
    );

    itlb_sweep #(.ENTRIES(ENTRIES)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (range_go),
        .start_lo  (reg_lo),
        .start_hi  (reg_hi),
        .start_sel (reg_sel),
        .busy      (busy),
        .idx       (sw_idx),
        .win_lo    (sw_lo),
        .win_hi    (sw_hi),
        .win_sel   (sw_sel),
        .fin       (fin)
    );

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        itlb_set #(.ENTRIES(ENTRIES)) u_set (
            .clk       (clk),
            .rst_n     (rst_n),
            .fill_en   (fill_en && (fill_set == SW'(s))),
            .fill_idx  (fill_idx),
            .fill_va   (fill_va),
            .fill_pa   (fill_pa),
            .fill_size (fill_size),
            .flush_all (full_go && reg_sel[s]),
            .sw_busy   (busy && sw_sel[s]),
            .sw_idx    (sw_idx),
            .sw_lo     (sw_lo),
            .sw_hi     (sw_hi),
            .lk_va     (lk_va),
            .lk_hit    (hit_v[s]),
            .lk_pa     (pa_v[s])
        );
    end

    // Lookup result of the requested set.
    assign lk_hit = hit_v[lk_set];
    assign lk_pa  = pa_v[lk_set];
endmodule

// File: tb/itlb_inval_top_tb.sv
`timescale 1ns/1ps
module itlb_inval_top_tb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fill_en = 1'b0;
    logic        fill_set = 1'b0;
    logic [2:0]  fill_idx = '0;
    logic [31:0] fill_va = '0;
    logic [31:0] fill_pa = '0;
    logic [1:0]  fill_size = '0;
    logic        lk_set = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_hit;
    logic [31:0] lk_pa;

    int n_chk = 0;
    int n_err = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    itlb_inval_top #(.ENTRIES(N)) u_dut (.*);

    // Lookup vectors for set 0 after the initial fill: {va, hit, pa}.
    localparam logic [64:0] VEC [8] = '{
        {32'h1000_0123, 1'b1, 32'h8000_0123},
        {32'h1001_ABCD, 1'b1, 32'h8100_ABCD},
        {32'h200F_FFFF, 1'b1, 32'h820F_FFFF},
        {32'h30AB_CDEF, 1'b1, 32'h90AB_CDEF},
        {32'h1000_2FFC, 1'b1, 32'h8000_5FFC},
        {32'h1000_1000, 1'b0, 32'h0},
        {32'h4000_1000, 1'b0, 32'h0},
        {32'h5000_0000, 1'b0, 32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic fill(input logic s, input logic [2:0] i, input logic [31:0] va,
                        input logic [31:0] pa, input logic [1:0] sz);
        @(negedge clk);
        fill_en = 1'b1; fill_set = s; fill_idx = i; fill_va = va; fill_pa = pa; fill_size = sz;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic look(input logic s, input logic [31:0] va, output logic h, output logic [31:0] pa);
        lk_set = s; lk_va = va;
        #1 h = lk_hit; pa = lk_pa;
    endtask

    task automatic fill_set_all(input logic s);
        fill(s, 3'd0, 32'h1000_0000, 32'h8000_0000, 2'd0);
        fill(s, 3'd1, 32'h1001_0000, 32'h8100_0000, 2'd1);
        fill(s, 3'd2, 32'h2000_0000, 32'h8200_0000, 2'd2);
        fill(s, 3'd3, 32'h3000_0000, 32'h9000_0000, 2'd3);
        fill(s, 3'd4, 32'h1000_2000, 32'h8000_5000, 2'd0);
        fill(s, 3'd5, 32'h4000_0000, 32'hA000_0000, 2'd0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic        h;
        logic [31:0] p;
        logic [31:0] d;
        int          cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        rd(12'h020, d); check("R1 cmd", d, 32'h0);
        rd(12'h12C, d); check("R1 done", d, 32'h0);
        rd(12'h038, d); check("R1 sel", d, 32'h0);
        rd(12'h024, d); check("R1 start", d, 32'h0);
        look(1'b0, 32'h0000_0000, h, p); check("R1 miss set0", {31'b0, h}, 32'h0);
        look(1'b1, 32'h0000_0000, h, p); check("R1 miss set1", {31'b0, h}, 32'h0);

        fill_set_all(1'b0);
        fill_set_all(1'b1);

        // R2: vector table of lookups.
        for (int k = 0; k < 8; k++) begin
            look(1'b0, VEC[k][64:33], h, p);
            check($sformatf("R2 hit vec%0d", k), {31'b0, h}, {31'b0, VEC[k][32]});
            if (VEC[k][32]) check($sformatf("R2 pa vec%0d", k), p, VEC[k][31:0]);
        end

        // R10: readback.
        wr(12'h024, 32'hDEAD_B000);
        wr(12'h028, 32'h1234_5FFF);
        wr(12'h038, 32'hFFFF_FFFF);
        rd(12'h024, d); check("R10 start", d, 32'hDEAD_B000);
        rd(12'h028, d); check("R10 end", d, 32'h1234_5FFF);
        rd(12'h038, d); check("R10 sel", d, 32'h3);

        // R9: unknown command does nothing (both sets selected).
        wr(12'h020, 32'h3);
        @(negedge clk);
        rd(12'h020, d); check("R9 busy", d, 32'h0);
        rd(12'h12C, d); check("R9 done", d, 32'h0);
        look(1'b0, 32'h1000_0123, h, p); check("R9 set0 kept", {31'b0, h}, 32'h1);
        look(1'b1, 32'h1000_0123, h, p); check("R9 set1 kept", {31'b0, h}, 32'h1);

        // R3/R5: full invalidation of set 1 only.
        wr(12'h038, 32'h2);
        wr(12'h020, 32'h2);
        look(1'b1, 32'h1000_0123, h, p); check("R3 set1 flushed i0", {31'b0, h}, 32'h0);
        look(1'b1, 32'h30AB_CDEF, h, p); check("R3 set1 flushed i3", {31'b0, h}, 32'h0);
        look(1'b0, 32'h1000_0123, h, p); check("R5 set0 untouched", {31'b0, h}, 32'h1);
        rd(12'h12C, d); check("R3 done not yet", d, 32'h0);
        @(negedge clk);
        rd(12'h12C, d); check("R3 done next cycle", d, 32'h1);

        // R6: nonzero write ignored, zero write clears.
        wr(12'h12C, 32'h5);
        rd(12'h12C, d); check("R6 nonzero kept", d, 32'h1);
        wr(12'h12C, 32'h0);
        rd(12'h12C, d); check("R6 cleared", d, 32'h0);

        fill_set_all(1'b1);

        // R4/R5/R7/R8: range sweep on set 0, window [0x1000_1000, 0x1001_0FFF].
        wr(12'h038, 32'h1);
        wr(12'h024, 32'h1000_1000);
        wr(12'h028, 32'h1001_0FFF);
        wr(12'h020, 32'h1);
        rd(12'h020, d); check("R7 busy bit31", d, 32'h8000_0000);
        look(1'b0, 32'h30AB_CDEF, h, p); check("R8 unchecked hidden", {31'b0, h}, 32'h0);
        look(1'b1, 32'h30AB_CDEF, h, p); check("R8 unswept set visible", {31'b0, h}, 32'h1);
        wr(12'h020, 32'h2);
        cnt = 0;
        do begin
            @(negedge clk); cnt++;
            rd(12'h020, d);
        end while (d[31] && cnt < 100);
        check("R4 sweep ends", d, 32'h0);
        rd(12'h12C, d); check("R4 done", d, 32'h1);
        look(1'b0, 32'h1000_0123, h, p); check("R7 full ignored, i0 below window kept", {31'b0, h}, 32'h1);
        look(1'b0, 32'h1001_ABCD, h, p); check("R4 i1 overlap dropped", {31'b0, h}, 32'h0);
        look(1'b0, 32'h1000_2FFC, h, p); check("R4 i4 inside dropped", {31'b0, h}, 32'h0);
        look(1'b0, 32'h200F_FFFF, h, p); check("R4 i2 kept", {31'b0, h}, 32'h1);
        look(1'b0, 32'h30AB_CDEF, h, p); check("R4 i3 kept", {31'b0, h}, 32'h1);
        look(1'b1, 32'h1001_ABCD, h, p); check("R5 set1 i1 kept", {31'b0, h}, 32'h1);

        // R4: second sweep on both sets, single-byte overlap and end+1 boundary.
        wr(12'h12C, 32'h0);
        wr(12'h038, 32'h3);
        wr(12'h024, 32'h200F_FFFF);
        wr(12'h028, 32'h2FFF_FFFF);
        wr(12'h020, 32'h1);
        cnt = 0;
        do begin
            @(negedge clk); cnt++;
            rd(12'h020, d);
        end while (d[31] && cnt < 100);
        check("R4 sweep length", cnt, N);
        rd(12'h12C, d); check("R4 done after sweep", d, 32'h1);
        look(1'b0, 32'h2000_0000, h, p); check("R4 set0 one-byte overlap dropped", {31'b0, h}, 32'h0);
        look(1'b1, 32'h2000_0000, h, p); check("R4 set1 one-byte overlap dropped", {31'b0, h}, 32'h0);
        look(1'b0, 32'h3000_0000, h, p); check("R4 base at end+1 kept", {31'b0, h}, 32'h1);
        look(1'b1, 32'h1000_0123, h, p); check("R4 set1 i0 kept", {31'b0, h}, 32'h1);
        look(1'b0, 32'h4000_0ABC, h, p); check("R2 pa i5", p, 32'hA000_0ABC);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule